// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave with Page Programming

This block is a slave on a two-wire serial bus (I2C) that fronts a byte-wide storage array of 256 locations, split into 16 pages of 16 bytes. A master writes one byte or a whole page, reads from the current position, or sets a position and then reads from it after a repeated START. The block oversamples SCL and SDA with its own system clock and pulls SDA low through an open-drain enable. It never drives SDA high.

Four of these slaves can share one bus. The upper five bits of the 7-bit device address are fixed, and two strap inputs set the low two bits. One address counter serves both directions. It wraps inside the current page on writes and across the whole array on reads. Written bytes are collected in a page buffer and go into the array only when the master sends STOP. A programming timer then runs. While it runs, the block refuses its own address, so the master can poll for completion by retrying the address byte until it is acknowledged.

The block has no streaming port. All data moves over the two bus lines, so it has no valid/ready back-pressure at its edge. The only flow control is the address NACK during programming. The master must poll until it gets an acknowledge.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits, sent MSB first, equal binary 10100 followed by strap_i[1] and strap_i[0]. Bit 0 is the direction: 0 means write and 1 means read. For any other address the block answers NACK and leaves SDA released until the next START or STOP.
- R2: In a write transaction, the first byte after the address byte is acknowledged and loads the address counter. Every later byte is acknowledged and treated as data for the location the counter points to.
- R3: After each data byte, only the low 4 bits of the counter advance, so writing wraps from the last byte of a page to its first byte. When a transaction sends more than 16 data bytes, the later bytes overwrite the earlier ones in that page.
- R4: Data bytes are held in a page buffer and written to the array only when STOP is detected. Before that STOP, a read of a location still returns its old contents.
- R5: A read transaction returns data MSB first, starting at the counter value. The counter advances by one after each byte read and rolls over from 255 to 0. A read of any length is accepted.
- R6: A random read works as follows: a write transaction that carries only the memory address, then a repeated START, then a read transaction that returns data from that address.
- R7: A STOP that commits data starts a programming cycle of BUSY_CYCLES system clocks. During this cycle the device address is answered with NACK. After it ends, the address is acknowledged again.
- R8: When the master answers a read byte with NACK, the block stops sending, leaves SDA released, and does not move the counter until the next START or STOP.
- R9: After reset, SDA is released and the counter and every location hold 0. A START or STOP at any bit position aborts the current frame and releases SDA. SDA changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_i | input | 2 | Pin-strapped low bits of the device address |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | When 1, the pad pulls SDA low |

## Verification
The bench tries these input patterns:
- Addresses that differ from the device's own in the strap bits and in the fixed prefix, which separates a correct match from a partial one.
- A two-byte write that starts at the last byte of a page and an 18-byte write into one page. Read back, these separate page wrap from linear increment and show the overwrite of the first slots.
- A full-page write followed by a read before STOP, which shows whether data is buffered or written straight through.
- A read that crosses address 255, which separates array-wide wrap from page wrap.
- Polling right after each commit, a master NACK followed by extra clocks, and a START halfway through an address byte, which check the programming lockout, the release after NACK and the frame abort against the reference model.

// File: rtl/eeprom_i2c_pkg.sv
`timescale 1ns/1ps
package eeprom_i2c_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WADDR,
    ST_WDATA,
    ST_READ,
    ST_WAIT
  } slv_state_e;

  localparam logic [4:0] DEV_PREFIX = 5'b10100;
  localparam int BYTE_W = 8;
endpackage

// File: rtl/i2c_line_sync.sv
`timescale 1ns/1ps
module i2c_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic [1:0] scl_ff, sda_ff;
  logic       scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= 2'b11;
      sda_ff <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[0], scl_i};
      sda_ff <= {sda_ff[0], sda_i};
      scl_q  <= scl_ff[1];
      sda_q  <= sda_ff[1];
    end
  end

  assign sda_o   = sda_ff[1];
  assign rise_o  = scl_ff[1] & ~scl_q;
  assign fall_o  = ~scl_ff[1] & scl_q;
  assign start_o = scl_ff[1] & scl_q & sda_q & ~sda_ff[1];
  assign stop_o  = scl_ff[1] & scl_q & ~sda_q & sda_ff[1];
endmodule

// File: rtl/eeprom_page_buf.sv
`timescale 1ns/1ps
module eeprom_page_buf #(
  parameter int PAGE_W = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              we_i,
  input  logic [PAGE_W-1:0]                 slot_i,
  input  logic [7:0]                        data_i,
  input  logic                              clear_i,
  output logic [(1<<PAGE_W)-1:0][7:0]       bytes_o,
  output logic [(1<<PAGE_W)-1:0]            valid_o
);
  localparam int PB = 1 << PAGE_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bytes_o <= '0;
      valid_o <= '0;
    end else if (clear_i) begin
      valid_o <= '0;
    end else if (we_i) begin
      bytes_o[slot_i] <= data_i;
      valid_o[slot_i] <= 1'b1;
    end
  end

  assert_clear_empties_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (valid_o == '0));
  assert_fill_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && !clear_i) |=> valid_o[$past(slot_i)]);
endmodule

// File: rtl/eeprom_cell_array.sv
`timescale 1ns/1ps
module eeprom_cell_array #(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              commit_i,
  input  logic [ADDR_W-PAGE_W-1:0]          page_i,
  input  logic [(1<<PAGE_W)-1:0][7:0]       bytes_i,
  input  logic [(1<<PAGE_W)-1:0]            valid_i,
  input  logic [ADDR_W-1:0]                 rd_addr_i,
  output logic [7:0]                        rd_data_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PB    = 1 << PAGE_W;
  localparam int PGW   = ADDR_W - PAGE_W;

  logic [7:0] cell_view [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    localparam logic [PGW-1:0]    PG_ID = PGW'(g / PB);
    localparam logic [PAGE_W-1:0] SLOT  = PAGE_W'(g % PB);
    logic [7:0] cell_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cell_q <= '0;
      else if (commit_i && page_i == PG_ID && valid_i[SLOT])
        cell_q <= bytes_i[SLOT];
    end
    assign cell_view[g] = cell_q;
  end

  assign rd_data_o = cell_view[rd_addr_i];
endmodule

// File: rtl/eeprom_i2c_slave.sv
`timescale 1ns/1ps
module eeprom_i2c_slave #(
  parameter int ADDR_W      = 8,
  parameter int PAGE_W      = 4,
  parameter int BUSY_CYCLES = 5200000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] strap_i,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o
);
  import eeprom_i2c_pkg::*;

  localparam int PB     = 1 << PAGE_W;
  localparam int PGW    = ADDR_W - PAGE_W;
  localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);

  logic sda_s, start_ev, stop_ev, rise_ev, fall_ev;

  i2c_line_sync u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_o(sda_s), .start_o(start_ev), .stop_o(stop_ev),
    .rise_o(rise_ev), .fall_o(fall_ev)
  );

  slv_state_e          state;
  logic [3:0]          bcnt;
  logic [BYTE_W-1:0]   shreg, rd_sh;
  logic [ADDR_W-1:0]   ptr;
  logic                m_ack, oe;
  logic [BUSY_W-1:0]   busy_cnt;
  logic                busy;
  logic [PGW-1:0]      pg_base;
  logic [PB-1:0][7:0]  pb_bytes;
  logic [PB-1:0]       pb_valid;
  logic [7:0]          rd_data;
  logic                pb_we, commit, active, byte_end, frame_end, dev_hit;

  assign busy      = (busy_cnt != '0);
  assign active    = (state != ST_IDLE) && (state != ST_WAIT);
  assign byte_end  = fall_ev && (bcnt == 4'd8);
  assign frame_end = fall_ev && (bcnt == 4'd9);
  assign dev_hit   = (shreg[7:1] == {DEV_PREFIX, strap_i});
  assign pb_we     = byte_end && (state == ST_WDATA) && !start_ev && !stop_ev;
  assign commit    = stop_ev && (|pb_valid);

  eeprom_page_buf #(.PAGE_W(PAGE_W)) u_pbuf (
    .clk(clk), .rst_n(rst_n), .we_i(pb_we), .slot_i(ptr[PAGE_W-1:0]),
    .data_i(shreg), .clear_i(commit), .bytes_o(pb_bytes), .valid_o(pb_valid)
  );

  eeprom_cell_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_array (
    .clk(clk), .rst_n(rst_n), .commit_i(commit), .page_i(pg_base),
    .bytes_i(pb_bytes), .valid_i(pb_valid), .rd_addr_i(ptr), .rd_data_o(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      busy_cnt <= '0;
    else if (commit)
      busy_cnt <= BUSY_W'(BUSY_CYCLES);
    else if (busy)
      busy_cnt <= busy_cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bcnt    <= '0;
      shreg   <= '0;
      rd_sh   <= '0;
      ptr     <= '0;
      m_ack   <= 1'b0;
      oe      <= 1'b0;
      pg_base <= '0;
    end else if (start_ev) begin
      state <= ST_DEV;
      bcnt  <= '0;
      oe    <= 1'b0;
    end else if (stop_ev) begin
      state <= ST_IDLE;
      bcnt  <= '0;
      oe    <= 1'b0;
    end else if (active) begin
      if (rise_ev) begin
        if (bcnt < 4'd8) shreg <= {shreg[6:0], sda_s};
        else             m_ack <= ~sda_s;
        bcnt <= bcnt + 4'd1;
      end
      if (byte_end) begin
        unique case (state)
          ST_DEV: begin
            if (dev_hit && !busy) begin
              oe    <= 1'b1;
              state <= shreg[0] ? ST_READ : ST_WADDR;
            end else begin
              state <= ST_WAIT;
            end
          end
          ST_WADDR: begin
            oe    <= 1'b1;
            ptr   <= ADDR_W'(shreg);
            state <= ST_WDATA;
          end
          ST_WDATA: begin
            oe      <= 1'b1;
            pg_base <= ptr[ADDR_W-1:PAGE_W];
            ptr     <= {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + 1'b1};
          end
          ST_READ: begin
            oe  <= 1'b0;
            ptr <= ptr + 1'b1;
          end
          default: ;
        endcase
      end else if (frame_end) begin
        bcnt <= '0;
        if (state == ST_READ) begin
          if (m_ack) begin
            rd_sh <= rd_data;
            oe    <= ~rd_data[7];
          end else begin
            oe    <= 1'b0;
            state <= ST_WAIT;
          end
        end else begin
          oe <= 1'b0;
        end
      end else if (fall_ev && state == ST_READ && bcnt != 4'd0) begin
        rd_sh <= {rd_sh[6:0], 1'b0};
        oe    <= ~rd_sh[6];
      end
    end
  end

  assign sda_oe_o = oe;

  assert_foreign_nack_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DEV && byte_end && shreg[7:3] != DEV_PREFIX) |=> !sda_oe_o);
  assert_page_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WDATA && byte_end && !start_ev && !stop_ev)
      |=> ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W]));
  assert_commit_on_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_ev));
  assert_read_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_READ && byte_end && !start_ev && !stop_ev)
      |=> ptr == $past(ptr) + 1'b1);
  assert_busy_nack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && state == ST_DEV && byte_end) |=> !sda_oe_o);
  assert_wait_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT) |-> !sda_oe_o);
  assert_event_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ev || stop_ev) |=> !sda_oe_o);
endmodule

// File: tb/eeprom_i2c_slave_tb.sv
`timescale 1ns/1ps
module eeprom_i2c_slave_tb_top;
  localparam int Q    = 10;
  localparam int BUSY = 400;
  typedef logic [7:0] bq_t [$];

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic [1:0] strap = 2'b01;
  logic sda_oe;
  wire  sda_line = sda_m & ~sda_oe;

  localparam logic [7:0] DEVW = 8'hA2;
  localparam logic [7:0] DEVR = 8'hA3;

  always #2.5 clk = ~clk;

  eeprom_i2c_slave #(.BUSY_CYCLES(BUSY)) dut_i (
    .clk(clk), .rst_n(rst_n), .strap_i(strap),
    .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe)
  );

  int n_chk = 0, n_err = 0, glitches = 0;
  bit done = 0;
  int mem_m [256];
  int mptr = 0;
  int pend_a [$];
  int pend_v [$];

  // every-clock comparison: the model lets SDA move only while SCL is low (R9)
  logic prev_scl = 1'b1, prev_oe = 1'b0;
  always @(posedge clk) begin
    if (rst_n && scl_m && prev_scl && sda_oe !== prev_oe) glitches++;
    prev_scl <= scl_m;
    prev_oe  <= sda_oe;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic bit_out(input logic b);
    sda_m = b; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bit_in(output logic b);
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    b = sda_line; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(s);
    acked = ~s;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) bit_in(d[i]);
    bit_out(~give_ack);
  endtask

  task automatic model_commit();
    foreach (pend_a[i]) mem_m[pend_a[i]] = pend_v[i];
    pend_a.delete();
    pend_v.delete();
  endtask

  task automatic rd_n(input string req, input int n);
    logic [7:0] d;
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, d);
      chk(req, d, mem_m[mptr]);
      mptr = (mptr + 1) % 256;
    end
  endtask

  task automatic send_data(input bq_t d);
    logic a;
    foreach (d[i]) begin
      send_byte(d[i], a);
      chk("R2 data byte ack", a, 1);
      pend_a.push_back(mptr);
      pend_v.push_back(d[i]);
      mptr = (mptr & 8'hF0) | ((mptr + 1) & 8'h0F);
    end
  endtask

  task automatic open_write(input logic [7:0] addr);
    logic a;
    bus_start();
    send_byte(DEVW, a); chk("R1 own write address ack", a, 1);
    send_byte(addr, a); chk("R2 memory address ack", a, 1);
    mptr = addr;
  endtask

  task automatic page_write(input logic [7:0] addr, input bq_t d);
    open_write(addr);
    send_data(d);
    bus_stop();
    model_commit();
  endtask

  task automatic poll_ready();
    int polls = 0;
    logic a = 1'b0;
    while (!a && polls < 30) begin
      bus_start();
      send_byte(DEVW, a);
      bus_stop();
      polls++;
      if (polls == 1) chk("R7 address refused while programming", a, 0);
    end
    chk("R7 address accepted after programming", a, 1);
  endtask

  task automatic current_read(input int n);
    logic a;
    bus_start();
    send_byte(DEVR, a); chk("R5 read address ack", a, 1);
    rd_n("R5 current read data", n);
    bus_stop();
  endtask

  task automatic random_read(input logic [7:0] addr, input int n);
    open_write(addr);
    begin
      logic a;
      bus_start();
      send_byte(DEVR, a); chk("R6 read after repeated start ack", a, 1);
    end
    rd_n("R6 random read data", n);
    bus_stop();
  endtask

  initial begin
    tick(BUSY * 475);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    bq_t d;
    logic a;
    logic [7:0] b;
    foreach (mem_m[i]) mem_m[i] = 0;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    chk("R9 SDA released after reset", sda_oe, 0);
    current_read(1);                       // R9: location 0 reads 0

    // R1: foreign addresses
    bus_start();
    send_byte(8'hA0, a); chk("R1 strap mismatch nack", a, 0);
    send_byte(8'h00, a); chk("R1 silent after mismatch", a, 0);
    bus_stop();
    bus_start();
    send_byte(8'h22, a); chk("R1 prefix mismatch nack", a, 0);
    bus_stop();

    // R3: page wrap from last byte of page 1
    d = '{8'h11, 8'h22};
    page_write(8'h1F, d);
    poll_ready();
    random_read(8'h1E, 3);
    random_read(8'h10, 2);

    // R3: 18 bytes into one page overwrite the first slots
    d.delete();
    for (int i = 0; i < 18; i++) d.push_back(8'(8'h80 + i));
    page_write(8'h40, d);
    poll_ready();
    random_read(8'h40, 17);

    // R4: buffered data not visible before STOP
    d.delete();
    for (int i = 0; i < 16; i++) d.push_back(8'(8'hC0 + i));
    open_write(8'h70);
    send_data(d);
    bus_start();
    send_byte(DEVR, a); chk("R4 read before stop ack", a, 1);
    rd_n("R4 old data before commit", 1);
    bus_stop();
    model_commit();
    poll_ready();
    random_read(8'h70, 16);

    // R5: read across the top of the array
    d = '{8'hA1, 8'hB2, 8'hC3, 8'hD4};
    page_write(8'hFC, d);
    poll_ready();
    random_read(8'hFD, 6);

    // R8: master NACK then extra clocks
    bus_start();
    send_byte(DEVR, a); chk("R8 read address ack", a, 1);
    rd_n("R8 byte before nack", 1);
    recv_byte(1'b0, b); chk("R8 SDA released after nack", b, 8'hFF);
    bus_stop();
    current_read(2);                        // counter unmoved by the extra clocks (R8)

    // R9: START in the middle of an address byte
    bus_start();
    for (int i = 7; i >= 4; i--) bit_out(DEVW[i]);
    bus_start();
    send_byte(DEVR, a); chk("R9 frame restarts after mid-byte START", a, 1);
    rd_n("R9 data after abort", 2);
    bus_stop();

    tick(20);
    chk("R9 SDA changes only while SCL low", glitches, 0);
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule